// File: doc/BRIEF.md
# Over-temperature Acquisition Guard

This block protects a device from overheating by watching the die temperature reading, a signed integer in whole degrees Celsius. When a valid die sample reaches the trip level, the guard latches an over-temperature state and forces the stream-acquisition enable low. The state clears only after a valid sample falls below a lower release level, so readings between the two levels cannot make the enable chatter. While the fault lasts, the guard emits a one-cycle warning pulse. The first pulse comes at the moment of trip and the next ones follow once per configured period, which is one second at the default clock.

The block also raises an early-warning flag that follows the last valid die sample against a separate, configurable operating limit. It keeps the last valid sample of every temperature source and reports the one picked by a source selector. Source 0 is the die sensor that drives the protection.

Top module: `otg_guard`

## Requirements
- R1: A die sample (source 0, `src_valid[0]` high) of at least TRIP_C (default 103) sets `over_temp_o` after one clock edge, and from then on `acq_en_o` is low.
- R2: A valid die sample below CLEAR_C (default 97) clears `over_temp_o` after one clock edge.
- R3: A valid die sample from CLEAR_C to TRIP_C-1 leaves `over_temp_o` unchanged.
- R4: A die sample with `src_valid[0]` low has no effect on `over_temp_o` or `early_warn_o`.
- R5: `acq_en_o` equals `acq_req` while `over_temp_o` is low, and is low while it is high.
- R6: `warn_pulse_o` is high in the first cycle in which `over_temp_o` is high.
- R7: While `over_temp_o` stays high, `warn_pulse_o` repeats exactly every PERIOD cycles after the first pulse. It is never high while `over_temp_o` is low.
- R8: A new trip after a release restarts the warning period, giving an immediate pulse.
- R9: A valid die sample above EARLY_C sets `early_warn_o` after one edge, and a valid die sample at or below EARLY_C clears it.
- R10: `rpt_temp_o` shows the last valid sample of source `src_sel`. Source i occupies bits [i*TEMP_W +: TEMP_W] of `src_temp`. A selector of NUM_SRC or more reports 0. A change of selector shows without delay, and a new sample shows after one edge.
- R11: After synchronous reset, `over_temp_o`, `early_warn_o` and `warn_pulse_o` are low, every stored sample is 0, and `acq_en_o` follows `acq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | NUM_SRC | Per-source sample strobe |
| src_temp | input | NUM_SRC*TEMP_W | Signed Celsius samples, source i at bits i*TEMP_W |
| src_sel | input | SEL_W | Source to report |
| acq_req | input | 1 | Requested acquisition enable |
| acq_en_o | output | 1 | Gated acquisition enable |
| over_temp_o | output | 1 | Over-temperature state |
| early_warn_o | output | 1 | Die sample above the operating limit |
| warn_pulse_o | output | 1 | Periodic warning pulse during the fault |
| rpt_temp_o | output | TEMP_W | Reported temperature of the selected source |

## Verification
The bench drives readings exactly at 102, 103, 97 and 96, because an off-by-one compare there would trip one degree late or release one degree early. It sends out-of-band values with the strobe low, which catches a guard that acts on invalid readings. It holds the fault across several periods and then re-trips soon after a release. A timer that is not restarted would then pulse late or drift, and a timer that keeps counting after release would emit stray pulses. Random readings clustered around both thresholds, with random selectors that include out-of-range codes, check the hysteresis band and the readback mux against a cycle-level model.

// File: rtl/otg_pkg.sv
// Package: shared types for the over-temperature guard.
// Assumes: nothing beyond IEEE 1800-2017.
package otg_pkg;
    // Protection state of the guard.
    typedef enum logic {
        GS_NORMAL  = 1'b0,
        GS_TRIPPED = 1'b1
    } guard_state_e;
endpackage

// File: rtl/otg_sample_bank.sv
// Module: otg_sample_bank
// Keeps the last valid sample of every temperature source and muxes the
// selected one to the readback output. Out-of-range selectors read 0.
// Assumes: samples are signed two's complement, source i at bits i*TEMP_W.
module otg_sample_bank #(
    parameter int TEMP_W  = 8,
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        smp_valid,
    input  logic [NUM_SRC*TEMP_W-1:0] smp_temp,
    input  logic [SEL_W-1:0]          sel,
    output logic [TEMP_W-1:0]         rpt_temp
);
    logic [TEMP_W-1:0] hold_q [NUM_SRC];

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        // Capture a source's sample on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[gi] <= '0;
            end else if (smp_valid[gi]) begin
                hold_q[gi] <= smp_temp[gi*TEMP_W +: TEMP_W];
            end
        end
    end

    // Select the reported source; unknown codes read as zero.
    always_comb begin
        rpt_temp = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                rpt_temp = hold_q[i];
            end
        end
    end
endmodule

// File: rtl/otg_hyst.sv
// Module: otg_hyst
// Hysteretic trip detector on the die reading plus the early-warning flag.
// Trips at or above TRIP_C, releases below CLEAR_C, holds in between.
// Assumes: CLEAR_C < TRIP_C; readings are signed whole degrees.
module otg_hyst
    import otg_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int TRIP_C  = 103,
    parameter int CLEAR_C = 97,
    parameter int EARLY_C = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              die_valid,
    input  logic [TEMP_W-1:0] die_temp,
    output logic              hot_o,
    output logic              early_o
);
    localparam logic signed [TEMP_W-1:0] TripLvl  = TEMP_W'(TRIP_C);
    localparam logic signed [TEMP_W-1:0] ClearLvl = TEMP_W'(CLEAR_C);
    localparam logic signed [TEMP_W-1:0] EarlyLvl = TEMP_W'(EARLY_C);

    guard_state_e state_q, state_d;
    logic         early_q;
    logic signed [TEMP_W-1:0] t_s;

    assign t_s = $signed(die_temp);

    // Next protection state from a valid reading.
    always_comb begin
        state_d = state_q;
        if (die_valid) begin
            if (t_s >= TripLvl) begin
                state_d = GS_TRIPPED;
            end else if (t_s < ClearLvl) begin
                state_d = GS_NORMAL;
            end
        end
    end

    // Register the protection state and the early flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_NORMAL;
            early_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (die_valid) begin
                early_q <= (t_s > EarlyLvl);
            end
        end
    end

    assign hot_o   = (state_q == GS_TRIPPED);
    assign early_o = early_q;
endmodule

// File: rtl/otg_warn_timer.sv
// Module: otg_warn_timer
// Emits a one-cycle pulse on the first hot cycle and every PERIOD cycles
// after while hot stays high; the phase restarts whenever hot drops.
// Assumes: PERIOD >= 2.
module otg_warn_timer #(
    parameter int PERIOD = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    output logic warn_o
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LastCnt = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Phase counter: held at zero while cool, wraps every PERIOD while hot.
    always_ff @(posedge clk) begin
        if (!rst_n || !hot) begin
            cnt_q <= '0;
        end else if (cnt_q == LastCnt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign warn_o = hot && (cnt_q == '0);
endmodule

// File: rtl/otg_guard.sv
// Module: otg_guard (top)
// Over-temperature acquisition guard: gates the acquisition enable from a
// hysteretic die-temperature trip, pulses a periodic warning during the
// fault, flags readings above an operating limit and reports a selected
// source's last sample. Source 0 is the die sensor.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module otg_guard #(
    parameter int TEMP_W  = 8,
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int TRIP_C  = 103,
    parameter int CLEAR_C = 97,
    parameter int EARLY_C = 80,
    parameter int PERIOD  = 250_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC*TEMP_W-1:0] src_temp,
    input  logic [SEL_W-1:0]          src_sel,
    input  logic                      acq_req,
    output logic                      acq_en_o,
    output logic                      over_temp_o,
    output logic                      early_warn_o,
    output logic                      warn_pulse_o,
    output logic [TEMP_W-1:0]         rpt_temp_o
);
    logic hot;

    otg_hyst #(
        .TEMP_W (TEMP_W),
        .TRIP_C (TRIP_C),
        .CLEAR_C(CLEAR_C),
        .EARLY_C(EARLY_C)
    ) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .die_valid(src_valid[0]),
        .die_temp (src_temp[TEMP_W-1:0]),
        .hot_o    (hot),
        .early_o  (early_warn_o)
    );

    otg_warn_timer #(
        .PERIOD(PERIOD)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hot   (hot),
        .warn_o(warn_pulse_o)
    );

    otg_sample_bank #(
        .TEMP_W (TEMP_W),
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(src_valid),
        .smp_temp (src_temp),
        .sel      (src_sel),
        .rpt_temp (rpt_temp_o)
    );

    // Force acquisition off while tripped.
    assign acq_en_o    = acq_req && !hot;
    assign over_temp_o = hot;
endmodule

// File: rtl/otg_guard_chk.sv
// Module: otg_guard_chk
// Property checker for otg_guard, attached by bind below.
// Assumes: PERIOD >= 2.
module otg_guard_chk #(
    parameter int TEMP_W  = 8,
    parameter int TRIP_C  = 103,
    parameter int CLEAR_C = 97,
    parameter int EARLY_C = 80,
    parameter int PERIOD  = 250_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              die_valid,
    input logic [TEMP_W-1:0] die_temp,
    input logic              acq_req,
    input logic              acq_en_o,
    input logic              over_temp_o,
    input logic              early_warn_o,
    input logic              warn_pulse_o
);
    localparam int GAP_W = $clog2(PERIOD + 1) + 1;
    logic signed [TEMP_W-1:0] t_s;
    logic [GAP_W-1:0] gap_q;

    assign t_s = $signed(die_temp);

    // Cycles since the last warning pulse during the current fault.
    always_ff @(posedge clk) begin
        if (!rst_n || !over_temp_o) begin
            gap_q <= '0;
        end else if (warn_pulse_o) begin
            gap_q <= GAP_W'(1);
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (die_valid && t_s >= TEMP_W'(TRIP_C)) |=> (over_temp_o && !acq_en_o)); // R1
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (die_valid && t_s < TEMP_W'(CLEAR_C)) |=> !over_temp_o); // R2
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (die_valid && t_s >= TEMP_W'(CLEAR_C) && t_s < TEMP_W'(TRIP_C)) |=> $stable(over_temp_o)); // R3
    AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !die_valid |=> ($stable(over_temp_o) && $stable(early_warn_o))); // R4
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !over_temp_o |-> (acq_en_o == acq_req)); // R5
    AST_FIRST_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(over_temp_o) |-> warn_pulse_o); // R6
    AST_QUIET_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        !over_temp_o |-> !warn_pulse_o); // R7
    AST_PERIOD_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (over_temp_o && gap_q == GAP_W'(PERIOD)) |-> warn_pulse_o); // R7
    AST_NO_EARLY_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_pulse_o && !$rose(over_temp_o)) |-> (gap_q == GAP_W'(PERIOD))); // R8
    AST_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        die_valid |=> (early_warn_o == ($past(t_s) > TEMP_W'(EARLY_C)))); // R9
endmodule

bind otg_guard otg_guard_chk #(
    .TEMP_W (TEMP_W),
    .TRIP_C (TRIP_C),
    .CLEAR_C(CLEAR_C),
    .EARLY_C(EARLY_C),
    .PERIOD (PERIOD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .die_valid   (src_valid[0]),
    .die_temp    (src_temp[TEMP_W-1:0]),
    .acq_req     (acq_req),
    .acq_en_o    (acq_en_o),
    .over_temp_o (over_temp_o),
    .early_warn_o(early_warn_o),
    .warn_pulse_o(warn_pulse_o)
);

// File: tb/otg_guard_tb.sv
// Bench for otg_guard: directed corners plus seeded random readings,
// compared each cycle against a model built from the requirements.
module otg_guard_tb;
    localparam int W  = 8;
    localparam int NS = 3;
    localparam int SW = 2;
    localparam int TRIP = 103;
    localparam int CLR  = 97;
    localparam int ERLY = 80;
    localparam int PER  = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic [NS-1:0]   src_valid;
    logic [NS*W-1:0] src_temp;
    logic [SW-1:0]   src_sel;
    logic acq_req;
    logic acq_en_o, over_temp_o, early_warn_o, warn_pulse_o;
    logic [W-1:0] rpt_temp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit m_hot, m_early, m_rose;
    int m_cnt;
    logic [W-1:0] m_samp [NS];
    string hot_tag;

    always #2 clk = ~clk;

    otg_guard #(
        .TEMP_W(W), .NUM_SRC(NS), .SEL_W(SW), .TRIP_C(TRIP),
        .CLEAR_C(CLR), .EARLY_C(ERLY), .PERIOD(PER)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_temp(src_temp),
        .src_sel(src_sel), .acq_req(acq_req), .acq_en_o(acq_en_o),
        .over_temp_o(over_temp_o), .early_warn_o(early_warn_o),
        .warn_pulse_o(warn_pulse_o), .rpt_temp_o(rpt_temp_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_rpt(logic [SW-1:0] s);
        return (int'(s) < NS) ? m_samp[s] : '0;
    endfunction

    // Compare all outputs with the model (called away from the edge).
    task automatic check_all(string warn_tag);
        check(hot_tag, int'(over_temp_o), int'(m_hot));
        check("R5 acq_en", int'(acq_en_o), int'(acq_req && !m_hot));
        check(m_rose ? "R6 first warn" : warn_tag, int'(warn_pulse_o),
              int'(m_hot && m_cnt == 0));
        check("R9 early", int'(early_warn_o), int'(m_early));
        check("R10 report", int'(rpt_temp_o), int'(exp_rpt(src_sel)));
    endtask

    // Drive one cycle of inputs, advance the model, then check.
    task automatic step(bit v0, int t0, bit req, int sel, string warn_tag);
        logic signed [W-1:0] ts;
        bit prev;
        src_valid[0] = v0;
        src_temp[W-1:0] = W'(t0);
        acq_req = req;
        src_sel = SW'(sel);
        ts = $signed(W'(t0));
        prev = m_hot;
        if (!m_hot) m_cnt = 0;
        else m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
        if (!v0) hot_tag = "R4 invalid ignored";
        else if (ts >= TRIP) hot_tag = "R1 trip";
        else if (ts < CLR) hot_tag = "R2 release";
        else hot_tag = "R3 band hold";
        if (v0) begin
            if (ts >= TRIP) m_hot = 1'b1;
            else if (ts < CLR) m_hot = 1'b0;
            m_early = (ts > ERLY);
        end
        for (int i = 0; i < NS; i++)
            if (src_valid[i]) m_samp[i] = src_temp[i*W +: W];
        m_rose = m_hot && !prev;
        @(posedge clk);
        @(negedge clk);
        check_all(warn_tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 1'b0;
        src_valid = '0;
        src_temp = '0;
        src_sel = '0;
        acq_req = 1'b1;
        m_hot = 0; m_early = 0; m_rose = 0; m_cnt = 0;
        for (int i = 0; i < NS; i++) m_samp[i] = '0;
        hot_tag = "R11 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state, with a hot sample presented during reset
        src_valid[0] = 1'b1;
        src_temp[W-1:0] = W'(120);
        @(posedge clk);
        @(negedge clk);
        check("R11 over", int'(over_temp_o), 0);
        check("R11 warn", int'(warn_pulse_o), 0);
        check("R11 early", int'(early_warn_o), 0);
        check("R11 rpt", int'(rpt_temp_o), 0);
        check("R11 acq", int'(acq_en_o), 1);
        rst_n = 1'b1;
        src_valid = '0;

        // directed corners on the die source
        step(1, 102, 1, 0, "R7");        // just below trip: stays cool
        step(1, 81, 1, 0, "R7");         // early flag on
        step(1, 80, 1, 0, "R7");         // R9 boundary: off at limit
        step(0, 127, 1, 0, "R7");        // R4: strobe low, ignored
        step(1, 103, 1, 0, "R7");        // R1 exact trip, R6 pulse
        for (int k = 0; k < 2 * PER + 3; k++)
            step((k % 3) == 0, 97 + (k % 6), k[0], 0, "R7 period");
        step(1, 97, 1, 0, "R7");         // R3 release edge holds
        step(1, 96, 1, 0, "R7");         // R2 release
        step(1, 99, 1, 0, "R7");         // R3 band hold while cool
        step(0, 0, 1, 0, "R7");
        step(1, 110, 1, 0, "R8 restart"); // R8 re-trip soon after
        for (int k = 0; k < 5; k++) step(0, 0, 1, 0, "R8 restart");
        step(1, -40, 0, 0, "R7");

        // seeded random readings clustered around the thresholds
        for (int k = 0; k < 4000; k++) begin
            int t;
            int pick = int'($urandom_range(0, 9));
            if (pick < 4) t = 94 + int'($urandom_range(0, 12));
            else if (pick < 6) t = 77 + int'($urandom_range(0, 6));
            else t = int'($urandom_range(0, 167)) - 40;
            for (int i = 1; i < NS; i++) begin
                src_valid[i] = ($urandom_range(0, 3) == 0);
                src_temp[i*W +: W] = W'($urandom);
            end
            step($urandom_range(0, 2) != 0, t, $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, 3)), "R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule